// File: doc/BRIEF.md
# Polyphase Interpolating Shaping Filter

This block shapes and interpolates a complex baseband stream. Every accepted input sample carries one I value and one Q value. Each value enters a short per-path history of the four most recent samples. Over the following four clock cycles the block emits four output samples, one per interpolation phase. So the output rate is four times the input rate.

Each phase output is a four-term dot product. It takes every fourth coefficient of a sixteen-entry set, starting at the phase index, and applies that set to the history from newest to oldest. The sum is rounded and saturated to a 20-bit result.

Coefficients are written one word at a time into a 256-word store. The I and Q paths can share one coefficient set or each use their own. The set that is actually used is captured at each accepted sample, together with the sharing mode. A write therefore never disturbs a burst of phases that is already in progress. A flush input empties the history and abandons any phases still pending.

Top module: `polyphase_shaper`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0 and out_i and out_q are 0 until the first output is produced.
- R2: The output for phase p is the signed sum over k = 0..3 of C[p+4k] times x[n-k]. Here x[n] is the newest accepted sample of that path and x[n-k] the one accepted k samples earlier. The sum is rounded as floor((sum + 2048) / 4096). out_i depends only on in_i and out_q depends only on in_q.
- R3: A sample accepted at a clock edge produces phases 0, 1, 2, 3 at the next four edges, with out_valid high and out_phase equal to p. Another sample may be accepted at the edge that produces phase 3 or at any later edge. With no sample pending, out_valid is 0.
- R4: Each accepted sample shifts the history by one position, and the oldest entry is dropped. History entries that have not yet been filled after reset or flush read as zero.
- R5: When cw_en is high, cw_data is written to cw_addr, which may be any of the 256 words. The coefficients in use are copied from the store only at an accepted sample. A write in the same cycle as an accepted sample is not used until the following accepted sample.
- R6: With sep_page = 0, coefficient C[k] for both paths is the word at address k, for k = 0..15.
- R7: With sep_page = 1, the I path uses address k and the Q path uses address 16 + k, so address bit 4 selects the Q set. sep_page is sampled only at an accepted sample.
- R8: flush clears the history of both paths and cancels all pending phases, so out_valid is 0 from the next cycle on. flush takes priority over in_valid: a sample offered in the same cycle is discarded.
- R9: A rounded result above 524287 is output as 524287, and one below -524288 is output as -524288 (20-bit two's complement).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears the history and cancels pending phases |
| in_valid | input | 1 | Offers a new I/Q sample |
| in_i | input | 16 | I sample, two's complement |
| in_q | input | 16 | Q sample, two's complement |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 8 | Coefficient word address |
| cw_data | input | 16 | Coefficient value, two's complement |
| sep_page | input | 1 | 0: shared coefficient set, 1: separate I and Q sets |
| out_valid | output | 1 | Output sample present |
| out_phase | output | 2 | Interpolation phase of the present output |
| out_i | output | 20 | I output, two's complement |
| out_q | output | 20 | Q output, two's complement |

## Verification
The assertions assume the source never offers a sample while a burst of phases is still running before its last phase, unless flush is raised in the same cycle. One property checks this spacing directly. The stimulus keeps to this rule by holding in_valid for a single cycle and then spending at least three cycles with it low. Flush and coefficient writes are placed freely, including mid-burst and in the same cycle as a sample. sep_page changes only between bursts, yet it is still free to differ from the value captured at the previous sample.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  localparam int SAMPLE_W    = 16;
  localparam int COEF_W      = 16;
  localparam int RESULT_W    = 20;
  localparam int NUM_PHASES  = 4;
  localparam int NUM_TAPS    = 4;
  localparam int COEF_ADDR_W = 8;
  localparam int ROUND_SHIFT = 12;

  // bit count for an index over v items, never below one
  function automatic int idx_bits(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/shaper_delay_line.sv
module shaper_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    shift_en,
  input  logic [W-1:0]            din,
  output logic [DEPTH-1:0][W-1:0] taps
);
  // taps[0] holds the newest sample, taps[DEPTH-1] the oldest
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        taps <= '0;
        else if (flush)    taps <= '0;
        else if (shift_en) taps <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        taps <= '0;
        else if (flush)    taps <= '0;
        else if (shift_en) taps <= {taps[DEPTH-2:0], din};
      end
    end
  endgenerate
endmodule

// File: rtl/shaper_phase_seq.sv
module shaper_phase_seq #(
  parameter int PHASES = 4,
  localparam int PW    = shaper_pkg::idx_bits(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          start,
  output logic          run,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  assign last = run && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (flush) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (start) begin
      run   <= 1'b1;
      phase <= '0;
    end else if (run) begin
      if (last) begin
        run   <= 1'b0;
        phase <= '0;
      end else begin
        phase <= phase + PW'(1);
      end
    end
  end
endmodule

// File: rtl/shaper_coef_store.sv
module shaper_coef_store #(
  parameter int CW    = 16,
  parameter int AW    = 8,
  parameter int NCOEF = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    load,
  input  logic                    sep_page,
  output logic [NCOEF-1:0][CW-1:0] coef_i,
  output logic [NCOEF-1:0][CW-1:0] coef_q
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] mem    [DEPTH];
  logic [CW-1:0] snap_i [NCOEF];
  logic [CW-1:0] snap_q [NCOEF];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // active set: copied from the store only when a sample is accepted
  for (genvar k = 0; k < NCOEF; k++) begin : g_slot
    localparam logic [AW-1:0] I_ADDR = AW'(k);
    localparam logic [AW-1:0] Q_ADDR = AW'(NCOEF + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_i[k] <= '0;
        snap_q[k] <= '0;
      end else if (load) begin
        snap_i[k] <= mem[I_ADDR];
        snap_q[k] <= sep_page ? mem[Q_ADDR] : mem[I_ADDR];
      end
    end

    assign coef_i[k] = snap_i[k];
    assign coef_q[k] = snap_q[k];
  end
endmodule

// File: rtl/shaper_mac.sv
module shaper_mac #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 20,
  parameter int TAPS   = 4,
  parameter int PHASES = 4,
  parameter int SHIFT  = 12,
  localparam int NCOEF = TAPS * PHASES,
  localparam int PW    = shaper_pkg::idx_bits(PHASES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     calc_en,
  input  logic [PW-1:0]            phase,
  input  logic [TAPS-1:0][DW-1:0]  taps,
  input  logic [NCOEF-1:0][CW-1:0] coefs,
  output logic [OW-1:0]            y
);
  localparam int CIW    = shaper_pkg::idx_bits(NCOEF);
  localparam int PROD_W = DW + CW;
  localparam int ACC_W  = PROD_W + shaper_pkg::idx_bits(TAPS);
  localparam int Q_W    = ACC_W - SHIFT + 1;
  localparam int HALF   = 1 << (SHIFT - 1);
  localparam logic signed [Q_W-1:0] QMAX = Q_W'((1 << (OW - 1)) - 1);
  localparam logic signed [Q_W-1:0] QMIN = Q_W'(-(1 << (OW - 1)));

  // round half up by SHIFT bits, then clamp into OW bits
  function automatic logic [OW-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W:0] biased;
    logic signed [Q_W-1:0] scaled;
    biased = $signed({acc[ACC_W-1], acc}) + $signed((ACC_W + 1)'(HALF));
    scaled = biased[ACC_W:SHIFT];
    if (scaled > QMAX) return QMAX[OW-1:0];
    if (scaled < QMIN) return QMIN[OW-1:0];
    return scaled[OW-1:0];
  endfunction

  logic signed [ACC_W-1:0] psum [TAPS+1];
  assign psum[0] = '0;

  // tap k pairs the sample k steps back with coefficient phase + k*PHASES
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [CIW-1:0] BASE = CIW'(k * PHASES);
    logic [CIW-1:0]           cidx;
    logic signed [PROD_W-1:0] prod;
    assign cidx        = BASE + CIW'(phase);
    assign prod        = $signed(taps[k]) * $signed(coefs[cidx]);
    assign psum[k + 1] = psum[k] + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       y <= '0;
    else if (calc_en) y <= round_sat(psum[TAPS]);
  end
endmodule

// File: rtl/polyphase_shaper.sv
module polyphase_shaper
  import shaper_pkg::*;
#(
  parameter int DW     = SAMPLE_W,
  parameter int CW     = COEF_W,
  parameter int OW     = RESULT_W,
  parameter int PHASES = NUM_PHASES,
  parameter int TAPS   = NUM_TAPS,
  parameter int CAW    = COEF_ADDR_W,
  parameter int SHIFT  = ROUND_SHIFT,
  localparam int PW    = idx_bits(PHASES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_i,
  input  logic [DW-1:0]  in_q,
  input  logic           cw_en,
  input  logic [CAW-1:0] cw_addr,
  input  logic [CW-1:0]  cw_data,
  input  logic           sep_page,
  output logic           out_valid,
  output logic [PW-1:0]  out_phase,
  output logic [OW-1:0]  out_i,
  output logic [OW-1:0]  out_q
);
  localparam int NCOEF = TAPS * PHASES;

  // named internal events, observed by the bound checker
  logic accept;
  logic calc_en;
  logic seq_run;
  logic seq_last;
  logic [PW-1:0] seq_phase;

  logic [TAPS-1:0][DW-1:0]  taps_i, taps_q;
  logic [NCOEF-1:0][CW-1:0] coef_i, coef_q;

  assign accept  = in_valid & ~flush;
  assign calc_en = seq_run & ~flush;

  shaper_phase_seq #(.PHASES(PHASES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .start (accept),
    .run   (seq_run),
    .phase (seq_phase),
    .last  (seq_last)
  );

  shaper_delay_line #(.W(DW), .DEPTH(TAPS)) u_hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .shift_en (accept),
    .din      (in_i),
    .taps     (taps_i)
  );

  shaper_delay_line #(.W(DW), .DEPTH(TAPS)) u_hist_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .shift_en (accept),
    .din      (in_q),
    .taps     (taps_q)
  );

  shaper_coef_store #(.CW(CW), .AW(CAW), .NCOEF(NCOEF)) u_coefs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cw_en),
    .wr_addr  (cw_addr),
    .wr_data  (cw_data),
    .load     (accept),
    .sep_page (sep_page),
    .coef_i   (coef_i),
    .coef_q   (coef_q)
  );

  shaper_mac #(
    .DW(DW), .CW(CW), .OW(OW), .TAPS(TAPS), .PHASES(PHASES), .SHIFT(SHIFT)
  ) u_mac_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .calc_en (calc_en),
    .phase   (seq_phase),
    .taps    (taps_i),
    .coefs   (coef_i),
    .y       (out_i)
  );

  shaper_mac #(
    .DW(DW), .CW(CW), .OW(OW), .TAPS(TAPS), .PHASES(PHASES), .SHIFT(SHIFT)
  ) u_mac_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .calc_en (calc_en),
    .phase   (seq_phase),
    .taps    (taps_q),
    .coefs   (coef_q),
    .y       (out_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_phase <= '0;
    end else begin
      out_valid <= calc_en;
      if (calc_en) out_phase <= seq_phase;
    end
  end
endmodule

// File: rtl/polyphase_shaper_chk.sv
module polyphase_shaper_chk #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int TAPS   = 4,
  parameter int PHASES = 4,
  localparam int PW    = shaper_pkg::idx_bits(PHASES),
  localparam int NCOEF = TAPS * PHASES
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  in_valid,
  input logic [DW-1:0]         in_i,
  input logic                  accept,
  input logic                  seq_run,
  input logic                  seq_last,
  input logic                  out_valid,
  input logic [PW-1:0]         out_phase,
  input logic [TAPS*DW-1:0]    taps,
  input logic [NCOEF*CW-1:0]   coef_i,
  input logic [NCOEF*CW-1:0]   coef_q
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush) |-> (!seq_run || seq_last)); // R3

  AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    accept ##1 !flush |=> (out_valid && out_phase == '0)); // R3

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != LAST_PH && !flush) |=>
      (out_valid && out_phase == $past(out_phase) + PW'(1))); // R3

  AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (taps[DW-1:0] == $past(in_i)) &&
               (taps[2*DW-1:DW] == $past(taps[DW-1:0]))); // R4

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(coef_i) && $stable(coef_q))); // R5

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (taps == '0)); // R8
endmodule

bind polyphase_shaper polyphase_shaper_chk #(
  .DW(DW), .CW(CW), .TAPS(TAPS), .PHASES(PHASES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_i      (in_i),
  .accept    (accept),
  .seq_run   (seq_run),
  .seq_last  (seq_last),
  .out_valid (out_valid),
  .out_phase (out_phase),
  .taps      (taps_i),
  .coef_i    (coef_i),
  .coef_q    (coef_q)
);

// File: tb/polyphase_shaper_tb.sv
`timescale 1ns/1ps
module polyphase_shaper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic        sep_page = 1'b0;
  logic        out_valid;
  logic [1:0]  out_phase;
  logic [19:0] out_i, out_q;

  always #2.5 clk = ~clk;

  polyphase_shaper u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .cw_en(cw_en), .cw_addr(cw_addr),
    .cw_data(cw_data), .sep_page(sep_page), .out_valid(out_valid),
    .out_phase(out_phase), .out_i(out_i), .out_q(out_q)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  mem [256];
  int  act_i [16], act_q [16];
  int  hist_i [4], hist_q [4];
  bit  m_run = 1'b0;
  int  m_ph = 0;
  bit  e_valid = 1'b0;
  int  e_phase = 0;
  int  e_i = 0, e_q = 0;

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int rnd_clamp(input longint s);
    longint r;
    r = (s + 2048) >>> 12;
    if (r > 524287)  r = 524287;
    if (r < -524288) r = -524288;
    return int'(r);
  endfunction

  function automatic longint phase_sum(input int h[4], input int c[16], input int p);
    longint s = 0;
    for (int k = 0; k < 4; k++) s += longint'(h[k]) * longint'(c[p + 4*k]);
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1'b0; m_ph = 0; e_valid = 1'b0; e_phase = 0; e_i = 0; e_q = 0;
      for (int k = 0; k < 4; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
      for (int k = 0; k < 16; k++) begin act_i[k] = 0; act_q[k] = 0; end
    end else if (flush) begin
      e_valid = 1'b0;
      m_run = 1'b0;
      for (int k = 0; k < 4; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
    end else begin
      if (m_run) begin
        e_valid = 1'b1;
        e_phase = m_ph;
        e_i = rnd_clamp(phase_sum(hist_i, act_i, m_ph));
        e_q = rnd_clamp(phase_sum(hist_q, act_q, m_ph));
        if (m_ph == 3) m_run = 1'b0;
        else m_ph++;
      end else begin
        e_valid = 1'b0;
      end
      if (in_valid) begin
        for (int k = 3; k > 0; k--) begin hist_i[k] = hist_i[k-1]; hist_q[k] = hist_q[k-1]; end
        hist_i[0] = s16(in_i);
        hist_q[0] = s16(in_q);
        for (int k = 0; k < 16; k++) begin
          act_i[k] = mem[k];
          act_q[k] = sep_page ? mem[16 + k] : mem[k];
        end
        m_run = 1'b1;
        m_ph = 0;
      end
    end
    if (cw_en) mem[cw_addr] = s16(cw_data);
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == e_valid, "out_valid", longint'(out_valid), longint'(e_valid));
      if (out_valid && e_valid) begin
        chk(int'(out_phase) == e_phase, "out_phase", longint'(out_phase), longint'(e_phase));
        chk(int'($signed(out_i)) == e_i, "out_i", longint'($signed(out_i)), longint'(e_i));
        chk(int'($signed(out_q)) == e_q, "out_q", longint'($signed(out_q)), longint'(e_q));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit v, input int di, input int dq, input bit w,
                       input int a, input int d, input bit f);
    @(negedge clk);
    in_valid = v; in_i = 16'(di); in_q = 16'(dq);
    cw_en = w; cw_addr = 8'(a); cw_data = 16'(d); flush = f;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic send(input int di, input int dq);
    drive(1, di, dq, 0, 0, 0, 0);
    idle(3);
  endtask

  task automatic wr(input int a, input int d);
    drive(0, 0, 0, 1, a, d, 0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "reset out_valid", longint'(out_valid), 0);
    chk(out_i == '0, "reset out_i", longint'(out_i), 0);
    chk(out_q == '0, "reset out_q", longint'(out_q), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "post-reset out_valid", longint'(out_valid), 0);

    // R6: shared coefficient set, address bit 4 region holds other values
    cur_req = "R6";
    sep_page = 1'b0;
    for (int k = 0; k < 16; k++) wr(k, (k + 1) * 1500 - 11000);
    for (int k = 0; k < 16; k++) wr(16 + k, 9000 - k * 1100);
    idle(1);

    // R2: impulse and varied samples
    cur_req = "R2";
    send(4096, -4096);
    send(0, 0);
    send(0, 0);
    send(0, 0);
    send(12345, -321);
    send(-20000, 30000);
    send(777, -32768);

    // R4: history of four, fifth sample pushes the first out
    cur_req = "R4";
    send(1000, 2000);
    send(-1000, 3000);
    send(500, -500);
    send(32767, 32767);
    send(0, 0);

    // R3: spaced samples and gaps with no output
    cur_req = "R3";
    idle(5);
    send(2222, -3333);
    idle(7);
    send(-4444, 5555);
    send(6000, 6000);

    // R7: separate sets for I and Q
    cur_req = "R7";
    @(negedge clk); sep_page = 1'b1;
    send(8000, 8000);
    send(-7000, 7000);
    send(3000, -3000);
    @(negedge clk); sep_page = 1'b0;
    send(1234, 1234);

    // R5: write in the same cycle as a sample, then a mid-burst write
    cur_req = "R5";
    drive(1, 5000, 6000, 1, 3, 20000, 0);
    idle(3);
    send(5000, 6000);
    @(negedge clk); sep_page = 1'b1;
    drive(1, -9000, 9000, 0, 0, 0, 0);
    wr(18, -15000);
    idle(2);
    send(-9000, 9000);
    send(100, 200);
    @(negedge clk); sep_page = 1'b0;

    // R8: flush mid-burst and flush together with a sample
    cur_req = "R8";
    send(9000, -9000);
    drive(1, 9000, 9000, 0, 0, 0, 0);
    idle(1);
    drive(0, 0, 0, 0, 0, 0, 1);
    idle(3);
    send(300, -300);
    drive(1, 25000, 25000, 0, 0, 0, 1);
    idle(3);
    send(400, 400);
    send(-400, 400);

    // R9: saturation in both directions
    cur_req = "R9";
    for (int k = 0; k < 16; k++) wr(k, 32767);
    idle(1);
    for (int j = 0; j < 5; j++) send(32767, -32768);
    for (int k = 0; k < 16; k++) wr(k, -32768);
    idle(1);
    for (int j = 0; j < 5; j++) send(-32768, 32767);

    idle(4);
    if (!done) begin
      done = 1'b1;
      report();
      $finish;
    end
  end
endmodule